// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Staged Settings

This block makes one pulse-width-modulated output from a single 32-bit control register. The output period comes from a phase accumulator. Each clock the accumulator adds a programmable step value. Each time the sum carries out of the accumulator, a new output cycle begins. The output frequency is therefore `step × f_clk / 2^STEP_W`. The high time comes from an 8-bit complemented divisor: larger divisor values give shorter pulses.

Software writes new step and divisor values into a staging copy, and may also set a request flag. While the flag is set, the hardware moves the staged values into the running copy at the next cycle boundary and clears the flag on the same clock edge. Any write made while the flag is still set is dropped. This keeps the running settings consistent at all times. The register port is a plain write strobe with write data and a combinational read-back.

Top module: `phase_pwm`

## Requirements
- R1: Register layout: bit 31 is the run enable, bit 30 is the update-request flag, bits 8 upward (STEP_W bits) hold the step value, and bits 7:0 hold the divisor. All other bits read as 0. A read returns the enable, the flag and the staged step and divisor.
- R2: When the step value b divides 2^STEP_W, one output period lasts 2^STEP_W / b clocks. Each period begins when the accumulator carries out.
- R3: With running divisor d, the output is high in every clock in which the top 8 bits of the accumulator are below 255 − d, and low otherwise.
- R4: While the enable is 0, the output is low and the accumulator is held at zero. After the enable is set, the first cycle starts from accumulator zero, so the output is high on the very first clock.
- R5: The staged values are copied into the running copy, and the flag clears, on the clock edge that ends an output cycle. If the enable is 0 or the running step is 0, there is no cycle in progress, and the copy happens on the next edge.
- R6: Every write made while the flag is set is ignored, including the enable bit. The running values that land are the ones staged before the flag was set.
- R7: A running step value of 0 keeps the output low.
- R8: After reset, the register reads 0, the output is low and no update is pending.
- R9: A write with bit 30 clear changes only the staged values. The output timing stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data |
| pwmOut | output | 1 | PWM output |

## Verification
The bench builds the block with STEP_W = 10. This brings every period into the range of 16 to 256 clocks. At that width, the exact period and the exact high count can be measured for steps 4 to 64 within a few hundred clocks per setting. It also keeps the wait from a mid-cycle request to its landing short enough to count clock by clock. The default width of 16 is only elaborated. At that width the top-8-bit compare and the staging path are unchanged.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  localparam int ENABLE_BIT = 31;
  localparam int REQ_BIT    = 30;
  localparam int STEP_LSB   = 8;
  localparam int DIV_W      = 8;

  typedef struct packed {
    logic run;   // enable is set, accumulator advances
    logic load;  // copy staged values into running copy
  } pwm_strobe_t;
endpackage

// File: rtl/phase_pwm_ctrl.sv
module phase_pwm_ctrl
  import phase_pwm_pkg::*;
#(
  parameter int STEP_W = 16   // step field width, 8..22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic              boundary,
  output pwm_strobe_t       strobe,
  output logic [STEP_W-1:0] stagedStep,
  output logic [DIV_W-1:0]  stagedDiv,
  output logic [31:0]       rdData
);
  logic              enableQ;
  logic              pendingQ;
  logic [STEP_W-1:0] stepQ;
  logic [DIV_W-1:0]  divQ;
  logic              acceptWr;
  logic              unusedWr;

  assign unusedWr = ^wrData;
  assign acceptWr = wrEn && !pendingQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      pendingQ <= 1'b0;
      stepQ    <= '0;
      divQ     <= '0;
    end else begin
      if (acceptWr) begin
        enableQ <= wrData[ENABLE_BIT];
        stepQ   <= wrData[STEP_LSB +: STEP_W];
        divQ    <= wrData[DIV_W-1:0];
      end
      if (acceptWr && wrData[REQ_BIT])
        pendingQ <= 1'b1;
      else if (pendingQ && boundary)
        pendingQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.run  = enableQ;
    strobe.load = pendingQ && boundary;
  end

  assign stagedStep = stepQ;
  assign stagedDiv  = divQ;

  always_comb begin
    rdData                         = '0;
    rdData[ENABLE_BIT]             = enableQ;
    rdData[REQ_BIT]                = pendingQ;
    rdData[STEP_LSB +: STEP_W]     = stepQ;
    rdData[DIV_W-1:0]              = divQ;
  end
endmodule

// File: rtl/phase_pwm_dp.sv
module phase_pwm_dp
  import phase_pwm_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwm_strobe_t       strobe,
  input  logic [STEP_W-1:0] stagedStep,
  input  logic [DIV_W-1:0]  stagedDiv,
  output logic              boundary,
  output logic              pwmOut,
  output logic [STEP_W-1:0] activeStep,
  output logic [STEP_W-1:0] accVal
);
  localparam int TOP_LSB = STEP_W - DIV_W;

  logic [STEP_W-1:0] accQ;
  logic [STEP_W-1:0] stepQ;
  logic [DIV_W-1:0]  divQ;
  logic [STEP_W:0]   sum;
  logic [DIV_W-1:0]  phaseTop;
  logic [DIV_W-1:0]  threshold;

  assign sum       = {1'b0, accQ} + {1'b0, stepQ};
  assign boundary  = !strobe.run || (stepQ == '0) || sum[STEP_W];
  assign phaseTop  = accQ[TOP_LSB +: DIV_W];
  assign threshold = 8'd255 - divQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      stepQ <= '0;
      divQ  <= '0;
    end else begin
      accQ <= strobe.run ? sum[STEP_W-1:0] : '0;
      if (strobe.load) begin
        stepQ <= stagedStep;
        divQ  <= stagedDiv;
      end
    end
  end

  assign pwmOut     = strobe.run && (stepQ != '0) && (phaseTop < threshold);
  assign activeStep = stepQ;
  assign accVal     = accQ;
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        pwmOut
);
  pwm_strobe_t       strobe;
  logic [STEP_W-1:0] stagedStep;
  logic [DIV_W-1:0]  stagedDiv;
  logic              boundary;
  logic [STEP_W-1:0] activeStep;
  logic [STEP_W-1:0] accVal;

  phase_pwm_ctrl #(.STEP_W(STEP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .boundary(boundary), .strobe(strobe),
    .stagedStep(stagedStep), .stagedDiv(stagedDiv), .rdData(rdData)
  );

  phase_pwm_dp #(.STEP_W(STEP_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stagedStep(stagedStep), .stagedDiv(stagedDiv),
    .boundary(boundary), .pwmOut(pwmOut),
    .activeStep(activeStep), .accVal(accVal)
  );
endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk #(
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       rdData,
  input logic              pwmOut,
  input logic              boundary,
  input logic [STEP_W-1:0] activeStep,
  input logic [STEP_W-1:0] accVal
);
  assert_low_when_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[31] |-> !pwmOut);

  assert_acc_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[31] |=> (rdData[31] || accVal == '0));

  assert_flag_waits_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[30] && !boundary) |=> rdData[30]);

  assert_frozen_while_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdData[30] |=> ($stable(rdData[31]) && $stable(rdData[29:0])));

  assert_zero_step_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (activeStep == '0) |-> !pwmOut);
endmodule

bind phase_pwm phase_pwm_chk #(.STEP_W(STEP_W)) i_chk (
  .clk(clk), .rstN(rstN), .rdData(rdData), .pwmOut(pwmOut),
  .boundary(boundary), .activeStep(activeStep), .accVal(accVal)
);

// File: tb/test_phase_pwm.sv
`timescale 1ns/1ps
module test_phase_pwm;
  localparam int SW = 10;
  localparam int FULL = 1 << SW;
  localparam int NVEC = 6;
  localparam int VEC [NVEC][2] = '{'{4, 0}, '{4, 128}, '{8, 100},
                                   '{16, 200}, '{32, 254}, '{64, 96}};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  phase_pwm #(.STEP_W(SW)) i_phase_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(input bit en, input bit req, input int step, input int dv);
    return {en, req, 30'(step << 8) | 30'(dv & 255)};
  endfunction

  // expected high clocks per period, from the compare rule of R3
  function automatic int expHigh(input int step, input int dv);
    int h = 0;
    for (int k = 0; k < FULL / step; k++)
      if (((k * step) >> (SW - 8)) < (255 - dv)) h++;
    return h;
  endfunction

  // call at a falling edge
  task automatic writeReg(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(output int hi, output int per);
    logic prev;
    int guard = 0;
    prev = pwmOut;
    @(negedge clk);
    while (!(!prev && pwmOut) && guard < 5000) begin
      prev = pwmOut; @(negedge clk); guard++;
    end
    hi = 0; per = 0;
    do begin
      if (pwmOut) hi++;
      per++;
      prev = pwmOut;
      @(negedge clk);
    end while (!(!prev && pwmOut) && per < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int hi, per, n, lows;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(rdData == 32'h0, "R8 reset read", rdData, 0);
    check(pwmOut == 1'b0, "R8 reset output", pwmOut, 0);

    // R7 zero step: enabled, request lands at once, output stays low
    writeReg(cfg(1, 1, 0, 0));
    repeat (4) @(negedge clk);
    check(rdData[30] == 1'b0, "R5 lands with zero step", rdData[30], 0);
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwmOut) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R7 zero step high clocks", lows, 0);

    // R2 R3 vector table
    for (int v = 0; v < NVEC; v++) begin
      writeReg(cfg(1, 1, VEC[v][0], VEC[v][1]));
      measure(hi, per);
      measure(hi, per);
      check(per == FULL / VEC[v][0], "R2 period", per, FULL / VEC[v][0]);
      check(hi == expHigh(VEC[v][0], VEC[v][1]), "R3 high clocks", hi,
            expHigh(VEC[v][0], VEC[v][1]));
    end

    // R9 R1 staging write without request
    writeReg(cfg(1, 0, 4, 0));
    check(rdData[17:8] == 10'd4 && rdData[7:0] == 8'd0 && rdData[31:30] == 2'b10,
          "R1 readback", rdData, cfg(1, 0, 4, 0));
    measure(hi, per);
    check(per == 16, "R9 period unchanged", per, 16);

    // R5 R6 mid-cycle request, second write ignored
    writeReg(cfg(1, 1, 4, 0));
    measure(hi, per);
    measure(hi, per);         // now at the first clock of a period
    writeReg(cfg(1, 1, 8, 100));
    writeReg(cfg(0, 1, 16, 50));
    check(rdData == cfg(1, 1, 8, 100), "R6 write ignored while pending", rdData,
          cfg(1, 1, 8, 100));
    n = 0;
    while (rdData[30] && n < 2000) begin
      n++; @(negedge clk);
    end
    check(n == 254, "R5 flag clears at period end", n, 254);
    check(rdData == cfg(1, 0, 8, 100), "R6 staged values kept", rdData, cfg(1, 0, 8, 100));
    measure(hi, per);
    check(per == 128, "R5 new period", per, 128);
    check(hi == expHigh(8, 100), "R6 new high clocks", hi, expHigh(8, 100));

    // R4 disable and restart
    writeReg(cfg(0, 0, 8, 100));
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwmOut) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R4 disabled high clocks", lows, 0);
    writeReg(cfg(1, 0, 8, 100));
    check(pwmOut == 1'b1, "R4 high on first clock", pwmOut, 1);
    n = 0;
    while (pwmOut && n < 2000) begin
      n++; @(negedge clk);
    end
    check(n == expHigh(8, 100), "R4 first pulse from zero", n, expHigh(8, 100));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule